// File: doc/BRIEF.md
# Convert-Start Serial ADC Output Model

This block models the digital side of a 16-bit sampling converter with a three-wire host link: a convert-start line, a serial clock from the host, and a tri-state serial data line. A rising edge on the convert line latches the parallel sample word, puts the data line into high impedance and starts a conversion of fixed length, counted on the system clock. When that count ends, the block enters the acquisition phase and reports that the result is ready.

When the host pulls the convert line low, the block drives the most significant bit of the result without waiting for any serial clock edge. Each later falling edge of the serial clock moves the line to the next lower bit, so fifteen falling edges bring out the rest of the word. Clocks beyond the last bit leave the line driven low. Each bit holds across a whole serial clock period, so the host may sample on either edge. The convert and serial clock pins are synchronised to the system clock. The data line is modelled as a data bit and a pad enable.

Top module: `adc_conv_sdo`

## Requirements
- R1: After reset, `sdo_oe_o`, `sdo_o` and `conv_done_o` are all 0.
- R2: SYNC_STAGES+1 clock edges after `cnv_i` rises, `sdo_oe_o` is 0 and `conv_done_o` is 0.
- R3: `conv_done_o` goes to 1 exactly SYNC_STAGES+1+CONV_CYCLES clock edges after `cnv_i` rises, and is still 0 one edge earlier.
- R4: With the conversion done, SYNC_STAGES+1 edges after `cnv_i` falls, `sdo_oe_o` is 1 and `sdo_o` carries bit DATA_W-1 of the sample word, with no serial clock edge needed.
- R5: Each falling edge of `sclk_i` while the line is driven moves `sdo_o` to the next lower bit, SYNC_STAGES+1 edges after the pin falls, so bit DATA_W-1-k is shown after k falling edges (k = 1 to DATA_W-1).
- R6: Falling edges of `sclk_i` after bit 0 has been shown leave `sdo_oe_o` at 1 and `sdo_o` at 0 while `cnv_i` stays low.
- R7: `sdo_o` does not change on a rising edge of `sclk_i` or while `sclk_i` is high.
- R8: If `cnv_i` falls before the conversion ends, `sdo_oe_o` stays 0 until `conv_done_o` is 1 and goes to 1 with bit DATA_W-1 one edge after `conv_done_o` rises.
- R9: The word on `sample_i` is captured when the rising edge of `cnv_i` is registered; later changes on `sample_i` do not change the bits shifted out.
- R10: `cnv_i` high at any point puts the line in high impedance (`sdo_oe_o` 0 after SYNC_STAGES+1 edges), and the next frame starts again from bit DATA_W-1.
- R11: Falling edges of `sclk_i` while the line is in high impedance do not move the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert-start line from the host |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| sample_i | input | DATA_W | Parallel sample word to be converted |
| conv_done_o | output | 1 | 1 when the conversion result is ready |
| sdo_o | output | 1 | Serial data bit, 0 while not driven |
| sdo_oe_o | output | 1 | Pad enable for the serial data line; 0 means high impedance |

## Verification
Every pin event reaches the outputs after the same SYNC_STAGES+1 edges (synchroniser plus one state register), and the ready flag arrives CONV_CYCLES edges after that from a convert rise. The bench drives pins on the falling clock edge, counts rising edges to the exact edge the result is due, and samples on the following falling edge. It also samples one edge earlier to prove the old value still holds. The bench sweeps walking-one words and edge patterns through full frames, cut-short frames, and conversions with an early convert fall.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic [0:0] {
        PH_ACQ  = 1'b0,
        PH_CONV = 1'b1
    } conv_phase_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_edge_t;

endpackage

// File: rtl/acs_edge_sync.sv
module acs_edge_sync
    import acs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    output pin_edge_t edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_o.level = s_q.chain[STAGES-1];
    assign edge_o.rise  = s_q.chain[STAGES-1] & ~s_q.prev;
    assign edge_o.fall  = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/acs_conv_timer.sv
module acs_conv_timer
    import acs_pkg::*;
#(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        conv_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_st_t;

    tmr_st_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.phase = PH_CONV;
            t_d.cnt   = '0;
            t_d.done  = 1'b0;
        end else if (t_q.phase == PH_CONV) begin
            if (t_q.cnt == LAST) begin
                t_d.phase = PH_ACQ;
                t_d.cnt   = '0;
                t_d.done  = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{phase: PH_ACQ, cnt: '0, done: 1'b0};
        else        t_q <= t_d;
    end

    assign done_o = t_q.done;

    // R2: a registered start clears the ready flag and enters conversion
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!t_q.done && t_q.phase == PH_CONV));

    // R3: the count never passes the conversion length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_CONV) |-> (t_q.cnt <= LAST));

    // R3: the last count step raises the ready flag
    p_done_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_CONV && t_q.cnt == LAST && !start_i) |=> t_q.done);

endmodule

// File: rtl/acs_shift_out.sv
module acs_shift_out
    import acs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_edge_t         cnv_i,
    input  pin_edge_t         sclk_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              oe;
        logic              bit_v;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        s_d = s_q;
        if (cnv_i.rise) begin
            s_d.word = sample_i;
        end
        if (cnv_i.level) begin
            s_d.idx = '0;
            s_d.oe  = 1'b0;
        end else begin
            s_d.oe = done_i;
            if (s_q.oe && sclk_i.fall && s_q.idx != IDX_END) begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
        shifted   = s_d.word << s_d.idx;
        s_d.bit_v = s_d.oe & shifted[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_o    = s_q.bit_v;
    assign sdo_oe_o = s_q.oe;

    // R10: convert line high releases the data line
    p_hiz_cnv_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_i.level |=> !s_q.oe);

    // R8: no drive while the result is not ready
    p_no_drive_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !s_q.oe);

    // R4: a convert fall with a ready result drives from the top bit
    p_msb_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_i.fall && done_i) |=> (s_q.oe && s_q.idx == '0));

    // R5: one serial fall moves exactly one bit
    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && sclk_i.fall && !cnv_i.level && s_q.idx < IDX_END)
        |=> (s_q.idx == $past(s_q.idx) + 1'b1));

    // R6: bit position saturates and the tail is low
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= IDX_END);
    p_tail_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && s_q.idx == IDX_END) |-> !s_q.bit_v);

    // R7: data holds while the serial clock is high or rising
    p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && sclk_i.level && !cnv_i.level) |=> $stable(s_q.bit_v));
    p_hold_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && sclk_i.rise && !cnv_i.level) |=> $stable(s_q.bit_v));

    // R11: serial falls while released do not move the position
    p_ignore_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.oe && !cnv_i.level) |=> (s_q.idx == $past(s_q.idx)));

endmodule

// File: rtl/adc_conv_sdo.sv
module adc_conv_sdo
    import acs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              conv_done_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    pin_edge_t cnv_e;
    pin_edge_t sclk_e;
    logic      done_w;

    acs_edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnv_i),
        .edge_o (cnv_e)
    );

    acs_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sclk_i),
        .edge_o (sclk_e)
    );

    acs_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cnv_e.rise),
        .done_o  (done_w)
    );

    acs_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv_e),
        .sclk_i   (sclk_e),
        .done_i   (done_w),
        .sample_i (sample_i),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o)
    );

    assign conv_done_o = done_w;

    // R1: quiet outputs straight after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sdo_oe_o && !sdo_o && !conv_done_o));

endmodule

// File: tb/adc_conv_sdo_tb_top.sv
module adc_conv_sdo_tb_top;

    localparam int W   = 16;
    localparam int C   = 40;
    localparam int SS  = 2;
    localparam int LAT = SS + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0;
    logic         sclk = 1'b0;
    logic [W-1:0] sample = '0;
    logic         done, sdo, sdo_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    adc_conv_sdo #(.DATA_W(W), .CONV_CYCLES(C), .SYNC_STAGES(SS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_i       (cnv),
        .sclk_i      (sclk),
        .sample_i    (sample),
        .conv_done_o (done),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // raise convert, check release (R2, R10), then disturb the sample (R9)
    task automatic start_conv(input logic [W-1:0] w);
        @(negedge clk);
        sample = w;
        cnv    = 1'b1;
        edges(LAT);
        chk("R2 R10 oe", 32'(sdo_oe), 0);
        chk("R2 done", 32'(done), 0);
        sample = ~w;
    endtask

    task automatic wait_done_exact();
        edges(C - 1);
        chk("R3 done early", 32'(done), 0);
        edges(1);
        chk("R3 done due", 32'(done), 1);
    endtask

    // shift bits from..to (to inclusive) with one SCK fall each
    task automatic shift_bits(input logic [W-1:0] w, input int from, input int to);
        for (int b = from; b <= to; b++) begin
            sclk = 1'b1;
            edges(4);
            chk("R7 hold high", 32'(sdo), 32'(w[W-b]));
            sclk = 1'b0;
            edges(LAT - 1);
            chk("R5 not yet", 32'(sdo), 32'(w[W-b]));
            edges(1);
            chk("R5 bit R9", 32'(sdo), 32'(w[W-1-b]));
            chk("R5 oe", 32'(sdo_oe), 1);
        end
    endtask

    task automatic open_frame(input logic [W-1:0] w);
        cnv = 1'b0;
        edges(LAT - 1);
        chk("R4 not yet", 32'(sdo_oe), 0);
        edges(1);
        chk("R4 oe", 32'(sdo_oe), 1);
        chk("R4 msb R9", 32'(sdo), 32'(w[W-1]));
    endtask

    task automatic full_frame(input logic [W-1:0] w);
        start_conv(w);
        wait_done_exact();
        open_frame(w);
        shift_bits(w, 1, W - 1);
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1;
            edges(3);
            sclk = 1'b0;
            edges(LAT + 1);
            chk("R6 tail low", 32'(sdo), 0);
            chk("R6 tail oe", 32'(sdo_oe), 1);
        end
    endtask

    initial begin
        edges(3);
        chk("R1 oe", 32'(sdo_oe), 0);
        chk("R1 sdo", 32'(sdo), 0);
        chk("R1 done", 32'(done), 0);
        rst_n = 1'b1;
        edges(2);
        chk("R1 oe run", 32'(sdo_oe), 0);
        chk("R1 done run", 32'(done), 0);

        full_frame(16'h0000);
        full_frame(16'hFFFF);
        full_frame(16'h8000);
        full_frame(16'h0001);
        full_frame(16'hA5A5);
        full_frame(16'h5A5A);
        for (int b = 0; b < W; b++) full_frame(W'(1) << b);

        // R8 / R11: early convert fall, SCK falls while released
        start_conv(16'hC3A1);
        edges(5);
        cnv = 1'b0;
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1;
            edges(2);
            sclk = 1'b0;
            edges(2);
        end
        edges(C - 18);
        chk("R8 hiz before done", 32'(sdo_oe), 0);
        chk("R8 done low", 32'(done), 0);
        edges(1);
        chk("R8 done", 32'(done), 1);
        chk("R8 still hiz", 32'(sdo_oe), 0);
        edges(1);
        chk("R8 oe", 32'(sdo_oe), 1);
        chk("R8 msb", 32'(sdo), 32'(1));
        shift_bits(16'hC3A1, 1, 4);
        chk("R11 position", 32'(sdo), 32'(0));

        // R10: abort mid-frame, next frame restarts at top bit
        start_conv(16'h7E55);
        wait_done_exact();
        open_frame(16'h7E55);
        shift_bits(16'h7E55, 1, 5);
        full_frame(16'h9F3C);
        start_conv(16'h1234);
        chk("R10 released", 32'(sdo_oe), 0);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule